// File: doc/BRIEF.md
# Gate Control List Scheduler

This block runs a time-aware transmit schedule. A gate control list sits in an external RAM. Each 32-bit word of the list holds an interval in nanoseconds in its low bits and a vector of per-queue transmit gates above that interval. The block reads the list one word at a time through a read-address and read-data pair. It holds each entry's gate vector on its outputs for that entry's interval, then moves to the next entry. It restarts at entry 0 on every cycle boundary.

Time comes in from an external precision clock as a seconds word and a nanoseconds word. The start time and the cycle length are given in the same seconds-plus-nanoseconds form. A start time that already lies in the past is moved forward to the next whole cycle boundary after the moment the block is armed. The block computes this with a serial remainder unit. When frame preemption is in use, gate bit 0 of the current entry also drives a hold signal toward the preemption logic.

Top module: `gcl_sched`

## Requirements
- R1: After reset, while `en` is low, and before the first cycle start, `gate` is all ones and `hold` is 0.
- R2: A list word is decoded as interval = word[W-1:0] and gates = word[W+NQ-1:W]. The split width W is 16, 20 or 24 for `wcode` values 1, 2 or 3.
- R3: Entry k drives its gates from its own start time for its interval in nanoseconds of precision time. Entry k+1 then starts.
- R4: When the last entry (index `len`-1) has expired before the cycle ends, that entry's gates stay applied until the cycle boundary.
- R5: At each cycle boundary the list restarts at entry 0, even if entries remain unused.
- R6: While `fp_en` is 1 and the schedule runs, `hold` equals gate bit 0 (word bit W) of the current entry. While `fp_en` is 0, `hold` is 0.
- R7: When the base time lies after the arming time, the first cycle starts exactly at the base time.
- R8: When the base time is at or before the arming time `now`, the first cycle starts at base + (n+1)×cycle, where n = (now − base) ÷ cycle.
- R9: The list depth is 64 << (`dcode`−1) for `dcode` 1 to 5. The block arms only if `wcode` is 1 to 3, `dcode` is 1 to 5, 0 < `len` < depth, and both base and cycle are nonzero. Otherwise the gates stay open.
- R10: Clearing `en` stops the schedule. From the next clock, the gates are all ones and `hold` is 0.
- R11: While the schedule runs, new values of `len`, `wcode` and the cycle time take effect only at the next cycle boundary. The new cycle length then sets the following boundary.
- R12: Times are taken as seconds×10^9 + nanoseconds, so a schedule runs across a seconds rollover without a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Schedule enable |
| fp_en | input | 1 | Preemption in use: gate bit 0 drives hold |
| ptp_sec | input | 32 | Current time, seconds |
| ptp_ns | input | 30 | Current time, nanoseconds |
| base_sec | input | 32 | Start time, seconds |
| base_ns | input | 30 | Start time, nanoseconds |
| cyc_sec | input | 32 | Cycle length, seconds |
| cyc_ns | input | 30 | Cycle length, nanosecond remainder |
| wcode | input | 2 | Interval/gate split code (1:16, 2:20, 3:24) |
| dcode | input | 3 | List depth code (1..5) |
| len | input | AW+1 | Number of used entries |
| lst_addr | output | AW | List RAM read address (current entry) |
| lst_data | input | 32 | List RAM read data, same cycle |
| gate | output | NQ | Per-queue transmit gate vector |
| hold | output | 1 | Preemption hold |

## Verification
The main function is tried with a three-entry list whose intervals add up to less than the cycle. This tells entry stepping apart from the tail hold at the end of the list. The same list is then run with a cycle shorter than the list, written during a cycle, which separates a restart that truncates the list from a change that takes effect early. Word layouts for all three split widths are used, each with a gate pattern that decodes to a different value under any wrong split. Base times are set in the future, in the past by a non-whole number of cycles, and across a seconds rollover, which tells the exact start rule apart from an off-by-one cycle count.

// File: rtl/gcl_sched.sv
module gcl_sched #(
  parameter int NQ = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fp_en,
  input  logic [31:0]   ptp_sec,
  input  logic [29:0]   ptp_ns,
  input  logic [31:0]   base_sec,
  input  logic [29:0]   base_ns,
  input  logic [31:0]   cyc_sec,
  input  logic [29:0]   cyc_ns,
  input  logic [1:0]    wcode,
  input  logic [2:0]    dcode,
  input  logic [AW:0]   len,
  output logic [AW-1:0] lst_addr,
  input  logic [31:0]   lst_data,
  output logic [NQ-1:0] gate,
  output logic          hold
);
  localparam int TW = 64;
  localparam logic [TW-1:0] NS_PER_S = 64'd1000000000;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_CALC = 2'd1, S_WAIT = 2'd2, S_RUN = 2'd3} st_t;

  st_t           st;
  logic [TW-1:0] now, base, cyc, cap_now, cyc_cap, dvd, rem, bound, ent_start, ent_end;
  logic [6:0]    cnt;
  logic [AW-1:0] idx;
  logic [AW:0]   a_len, dep;
  logic [1:0]    a_w;
  logic [TW-1:0] a_cyc;
  logic          pend, tail, cfg_ok, running;
  logic [TW:0]   trial, rem_nx;
  logic [23:0]   ivl;
  logic [4:0]    wsh;
  logic [31:0]   gfield;

  assign now  = {32'd0, ptp_sec} * NS_PER_S + {34'd0, ptp_ns};
  assign base = {32'd0, base_sec} * NS_PER_S + {34'd0, base_ns};
  assign cyc  = {32'd0, cyc_sec} * NS_PER_S + {34'd0, cyc_ns};

  always_comb begin
    case (dcode)
      3'd1:    dep = (AW+1)'(64);
      3'd2:    dep = (AW+1)'(128);
      3'd3:    dep = (AW+1)'(256);
      3'd4:    dep = (AW+1)'(512);
      3'd5:    dep = (AW+1)'(1024);
      default: dep = '0;
    endcase
  end

  assign cfg_ok = en && (wcode != 2'd0) && (dep != '0) && (len != '0) &&
                  (len < dep) && (base != '0) && (cyc != '0);

  always_comb begin
    case (a_w)
      2'd1:    begin ivl = {8'd0, lst_data[15:0]}; wsh = 5'd16; end
      2'd2:    begin ivl = {4'd0, lst_data[19:0]}; wsh = 5'd20; end
      default: begin ivl = lst_data[23:0];         wsh = 5'd24; end
    endcase
  end

  assign gfield   = lst_data >> wsh;
  assign running  = (st == S_RUN);
  assign gate     = running ? gfield[NQ-1:0] : '1;
  assign hold     = running && fp_en && gfield[0];
  assign lst_addr = idx;

  assign trial  = {rem, dvd[TW-1]};
  assign rem_nx = (trial >= {1'b0, cyc_cap}) ? trial - {1'b0, cyc_cap} : trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cap_now   <= '0;
      cyc_cap   <= '0;
      dvd       <= '0;
      rem       <= '0;
      cnt       <= '0;
      bound     <= '0;
      ent_start <= '0;
      ent_end   <= '0;
      idx       <= '0;
      pend      <= 1'b0;
      tail      <= 1'b0;
      a_len     <= '0;
      a_w       <= 2'd1;
      a_cyc     <= '0;
    end else if (!en) begin
      st   <= S_IDLE;
      pend <= 1'b0;
      tail <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cfg_ok) begin
          a_len   <= len;
          a_w     <= wcode;
          a_cyc   <= cyc;
          cap_now <= now;
          cyc_cap <= cyc;
          if (base > now) begin
            bound <= base;
            st    <= S_WAIT;
          end else begin
            dvd <= now - base;
            rem <= '0;
            cnt <= '0;
            st  <= S_CALC;
          end
        end
        S_CALC: begin
          rem <= rem_nx[TW-1:0];
          dvd <= dvd << 1;
          cnt <= cnt + 7'd1;
          if (cnt == 7'(TW-1)) begin
            bound <= cap_now - rem_nx[TW-1:0] + cyc_cap;
            st    <= S_WAIT;
          end
        end
        default: begin
          if (now >= bound) begin
            st        <= S_RUN;
            idx       <= '0;
            ent_start <= bound;
            pend      <= 1'b1;
            tail      <= 1'b0;
            if (cfg_ok) begin
              a_len <= len;
              a_w   <= wcode;
              a_cyc <= cyc;
              bound <= bound + cyc;
            end else begin
              bound <= bound + a_cyc;
            end
          end else if (st == S_RUN) begin
            if (pend) begin
              ent_end <= ent_start + TW'(ivl);
              pend    <= 1'b0;
            end else if (!tail && now >= ent_end) begin
              if ({1'b0, idx} == a_len - 1'b1) begin
                tail <= 1'b1;
              end else begin
                idx       <= idx + 1'b1;
                ent_start <= ent_end;
                pend      <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

module gcl_sched_chk #(
  parameter int NQ = 8,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [1:0]    st,
  input logic [AW-1:0] lst_addr,
  input logic [AW:0]   a_len,
  input logic [NQ-1:0] gate,
  input logic          hold,
  input logic [63:0]   now,
  input logic [63:0]   bound,
  input logic [31:0]   cyc_sec,
  input logic [29:0]   cyc_ns
);
  assert_open_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate == '1 && !hold));

  assert_open_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd3) |-> (gate == '1 && !hold));

  assert_addr_in_list_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |-> ({1'b0, lst_addr} < a_len));

  assert_addr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && $past(st) == 2'd3 && lst_addr != $past(lst_addr))
      |-> (lst_addr == '0 || lst_addr == $past(lst_addr) + 1'b1));

  assert_restart_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == 2'd3 && now >= bound) |=> (lst_addr == '0));

  assert_zero_cycle_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && cyc_sec == '0 && cyc_ns == '0) |=> (st == 2'd0));
endmodule

bind gcl_sched gcl_sched_chk #(.NQ(NQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .st(st), .lst_addr(lst_addr),
  .a_len(a_len), .gate(gate), .hold(hold), .now(now), .bound(bound),
  .cyc_sec(cyc_sec), .cyc_ns(cyc_ns)
);

// File: tb/gcl_sched_test.sv
module gcl_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        fp_en = 1'b0;
  logic [31:0] ptp_sec, base_sec = '0, cyc_sec = '0;
  logic [29:0] ptp_ns, base_ns = '0, cyc_ns = '0;
  logic [1:0]  wcode = 2'd1;
  logic [2:0]  dcode = 3'd1;
  logic [10:0] len = 11'd3;
  logic [9:0]  lst_addr;
  logic [31:0] lst_data;
  logic [7:0]  gate;
  logic        hold;

  logic [31:0] ram [0:15];
  logic [63:0] tns = 64'd999_999_000;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tns <= tns + 64'd4;
  assign ptp_sec  = 32'(tns / 64'd1000000000);
  assign ptp_ns   = 30'(tns % 64'd1000000000);
  assign lst_data = ram[lst_addr[3:0]];

  gcl_sched uut (
    .clk(clk), .rst_n(rst_n), .en(en), .fp_en(fp_en),
    .ptp_sec(ptp_sec), .ptp_ns(ptp_ns), .base_sec(base_sec), .base_ns(base_ns),
    .cyc_sec(cyc_sec), .cyc_ns(cyc_ns), .wcode(wcode), .dcode(dcode), .len(len),
    .lst_addr(lst_addr), .lst_data(lst_data), .gate(gate), .hold(hold)
  );

  // {offset from start, expected gate, expected hold}
  localparam logic [40:0] VEC [0:7] = '{
    {32'd48,  8'h05, 1'b1}, {32'd152, 8'h0A, 1'b0},
    {32'd252, 8'h31, 1'b1}, {32'd352, 8'h31, 1'b1},
    {32'd448, 8'h05, 1'b1}, {32'd560, 8'h0A, 1'b0},
    {32'd660, 8'h31, 1'b1}, {32'd780, 8'h31, 1'b1}
  };

  function automatic string vtag(int i);
    case (i)
      3, 7:    return "R4 tail";
      4:       return "R5 restart R6";
      default: return "R3 step R6";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_t(input logic [63:0] t);
    while (tns < t) @(negedge clk);
  endtask

  task automatic set_base(input logic [63:0] b);
    base_sec = 32'(b / 64'd1000000000);
    base_ns  = 30'(b % 64'd1000000000);
  endtask

  task automatic chk(input string tag, input logic [7:0] eg, input logic eh);
    checks++;
    if (gate !== eg || hold !== eh) begin
      fails++;
      $display("FAIL %s at t=%0d: gate=%h hold=%b expected gate=%h hold=%b",
               tag, tns, gate, hold, eg, eh);
    end
  endtask

  task automatic stop_run();
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  logic [63:0] s, t;

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = '0;
    ram[0] = 32'h0005_0064;
    ram[1] = 32'h000A_0078;
    ram[2] = 32'h0031_0050;
    cyc_ns = 30'd400;
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'hFF, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    s = 64'd1_000_000_200;
    set_base(s);
    fp_en = 1'b1;
    en = 1'b1;
    wait_t(s - 4);
    chk("R7 R1 before start", 8'hFF, 1'b0);
    wait_t(s + 8);
    chk("R7 R12 start on base across second", 8'h05, 1'b1);

    for (int i = 0; i < 8; i++) begin
      wait_t(s + 64'(VEC[i][40:9]));
      chk(vtag(i), VEC[i][8:1], VEC[i][0]);
    end

    wait_t(s + 1000);
    cyc_ns = 30'd200;
    wait_t(s + 1152);
    chk("R11 old cycle kept", 8'h31, 1'b1);
    wait_t(s + 1352);
    chk("R11 new cycle applied", 8'h0A, 1'b0);
    wait_t(s + 1440);
    chk("R5 truncated restart", 8'h05, 1'b1);
    wait_t(s + 1592);
    chk("R5 last entry skipped", 8'h0A, 1'b0);
    fp_en = 1'b0;
    wait_t(s + 1640);
    chk("R6 hold off", 8'h05, 1'b0);

    stop_run();
    chk("R10 disable", 8'hFF, 1'b0);
    fp_en = 1'b1;
    cyc_ns = 30'd400;

    len = 11'd64;
    t = tns; set_base(t + 400); en = 1'b1;
    wait_t(t + 700);
    chk("R9 len at depth", 8'hFF, 1'b0);
    stop_run();
    dcode = 3'd2;
    t = tns; set_base(t + 400); en = 1'b1;
    wait_t(t + 448);
    chk("R9 depth code 2", 8'h05, 1'b1);
    stop_run();
    len = 11'd3; dcode = 3'd1; cyc_ns = '0;
    t = tns; set_base(t + 400); en = 1'b1;
    wait_t(t + 700);
    chk("R9 zero cycle", 8'hFF, 1'b0);
    stop_run();
    cyc_ns = 30'd400; wcode = 2'd0;
    t = tns; set_base(t + 400); en = 1'b1;
    wait_t(t + 700);
    chk("R9 bad width code", 8'hFF, 1'b0);
    stop_run();
    wcode = 2'd1;

    t = tns; set_base(t - 430); en = 1'b1;
    wait_t(t + 360);
    chk("R8 not yet started", 8'hFF, 1'b0);
    wait_t(t + 418);
    chk("R8 start next boundary", 8'h05, 1'b1);
    wait_t(t + 540);
    chk("R8 second entry", 8'h0A, 1'b0);
    stop_run();

    ram[0] = 32'h3C00_0064;
    ram[1] = 32'hC300_003C;
    len = 11'd2; wcode = 2'd3;
    t = tns; set_base(t + 400); en = 1'b1;
    wait_t(t + 448);
    chk("R2 width 24 entry 0", 8'h3C, 1'b0);
    wait_t(t + 532);
    chk("R2 width 24 entry 1", 8'hC3, 1'b1);
    wait_t(t + 600);
    chk("R4 width 24 tail", 8'hC3, 1'b1);
    stop_run();

    ram[0] = 32'h05A0_0064;
    len = 11'd1; wcode = 2'd2;
    t = tns; set_base(t + 400); en = 1'b1;
    wait_t(t + 448);
    chk("R2 width 20", 8'h5A, 1'b0);
    stop_run();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule